// File: doc/BRIEF.md
# Carrier Acquisition Sequencer

This block steps the carrier recovery loop of a QAM receiver through acquisition, from the moment symbol timing is locked until the carrier is tracked in decision-directed mode. It first holds the loop idle. It then gives the equalizer a blind warm-up period. Next it obtains a coarse frequency estimate, either by averaging AFC results or by selecting the next step of a frequency scan. After that it runs a coarse pull-in followed by a decision-directed pull-in. Once both succeed it stays in lock. Each stage is reported as a 3-bit status code, and the block drives the equalizer mode, phase-error enable, loop bandwidth choice, adaptation step-size shift and scan offset that the datapath blocks around it consume.

All state changes are taken on the symbol strobe, so status and lock flag move at most once per output symbol. The only exception is the synchronous restart, which acts on the next clock edge. The pull-in detector reports its outcome through success and failure pulses. A carrier lock indication guards the locked state. Every static select is expected to stay constant during operation.

Top module: `carrier_acq_ctrl`

## Requirements
- R1: After reset, status is 000 (idle), equalizer mode is 00 (initial), phase-error enable, lock flag, loop bandwidth outputs, step shift and scan offset are all 0.
- R2: State changes only in a cycle with sym_stb high, except for restart. Pull-in pulses, timing lock and carrier lock are ignored in cycles without sym_stb. In idle, a strobe with tlock high moves the state to initial (001).
- R3: The initial state (001) lasts exactly INIT_SHORT strobes when init_len_sel=0 and INIT_LONG strobes when it is 1, counted from the strobe after entry. During it, equalizer mode is 01 (CMA) and phase-error enable is 0.
- R4: When initial ends, the state goes to AFC (010) if afc_sel=1 and to frequency scan (011) if afc_sel=0.
- R5: The AFC state lasts AFC_SHORT strobes (afc_len_sel=0) or AFC_LONG strobes (afc_len_sel=1), then moves to coarse pull-in (100).
- R6: The scan state lasts one strobe, then moves to coarse pull-in (100). scan_ofs holds the current scan step and is 0 on the first pass.
- R7: pull_ok at a strobe moves coarse pull-in (100) to DD pull-in (110), and DD pull-in to lock (111). In lock, equalizer mode is 10 (DD) and cl_lock is 1.
- R8: pull_fail at a strobe in either pull-in state wins over a simultaneous pull_ok. With afc_sel=0 it increments scan_ofs by one and enters scan (011). With afc_sel=1 it re-enters AFC (010) and scan_ofs stays unchanged.
- R9: In lock, a strobe with car_ok low returns the state to DD pull-in (110).
- R10: A strobe with tlock low in any state returns to idle, and scan_ofs is cleared to 0.
- R11: restart high in any cycle returns the state to idle at the next clock edge, overriding every other input.
- R12: mu_shift is the power-of-two divisor exponent of the equalizer step: 0 in idle, 10 minus cma_mu_sel in states 001 to 110 (codes 00..11 give 1/1024..1/128), and 13 minus dd_mu_sel in lock (1/8192..1/1024). pe_en is 1 in states 010 and above.
- R13: In states 100 and 110, bw_code equals pib_sel and bw_trk is 0. In lock, bw_code equals trk_sel and bw_trk is 1. In all other states both are 0.
- R14: Status never shows the unused code 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous return to idle |
| sym_stb | input | 1 | Output symbol strobe, one cycle every symbol |
| tlock | input | 1 | Symbol timing loop locked |
| pull_ok | input | 1 | Pull-in success pulse |
| pull_fail | input | 1 | Pull-in failure pulse |
| car_ok | input | 1 | Carrier lock metric above threshold |
| init_len_sel | input | 1 | Initial period length select |
| afc_sel | input | 1 | 1: AFC estimate, 0: scan counter |
| afc_len_sel | input | 1 | AFC averaging count select |
| pib_sel | input | 1 | Pull-in bandwidth select |
| trk_sel | input | 1 | Tracking bandwidth select |
| cma_mu_sel | input | 2 | CMA step size code |
| dd_mu_sel | input | 2 | DD LMS step size code |
| status | output | 3 | Acquisition state code |
| eq_mode | output | 2 | Equalizer mode: 00 initial, 01 CMA, 10 DD |
| pe_en | output | 1 | Phase error enable |
| cl_lock | output | 1 | Carrier lock flag |
| bw_code | output | 1 | Selected loop bandwidth code |
| bw_trk | output | 1 | 1 when the tracking bandwidth is in use |
| mu_shift | output | 4 | Step size as right-shift amount |
| scan_ofs | output | SCAN_W | Frequency scan step |

## Verification
The pull-in detector can report success and failure in the same symbol. This can happen in either pull-in state, and the failure must win. The bench raises pull_ok and pull_fail together on one strobe during coarse pull-in in scan mode. It requires the state to fall back to scan with scan_ofs stepped by one, not to advance to DD pull-in. Restart together with a strobe and a pull_ok pulse is handled the same way: the only accepted result is idle.

// File: rtl/cacq_pkg.sv
package cacq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'b000,
    ST_INIT   = 3'b001,
    ST_AFC    = 3'b010,
    ST_SCAN   = 3'b011,
    ST_COARSE = 3'b100,
    ST_DDPULL = 3'b110,
    ST_LOCK   = 3'b111
  } cacq_st_e;

  typedef enum logic [1:0] {
    EQ_INIT = 2'b00,
    EQ_CMA  = 2'b01,
    EQ_DD   = 2'b10
  } cacq_eq_e;

  localparam logic [3:0] CMA_SHIFT_BASE = 4'd10;
  localparam logic [3:0] DD_SHIFT_BASE  = 4'd13;

endpackage

// File: rtl/cacq_sym_cnt.sv
module cacq_sym_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (clr)      cnt_nx = '0;
    else if (inc) cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cacq_scan_cnt.sv
module cacq_scan_cnt #(
  parameter int SCAN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [SCAN_W-1:0] ofs
);

  logic [SCAN_W-1:0] ofs_q, ofs_nx;

  always_comb begin
    ofs_nx = ofs_q;
    if (clr)       ofs_nx = '0;
    else if (step) ofs_nx = ofs_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ofs_q <= '0;
    else        ofs_q <= ofs_nx;
  end

  assign ofs = ofs_q;

endmodule

// File: rtl/cacq_fsm.sv
module cacq_fsm
  import cacq_pkg::*;
#(
  parameter int INIT_SHORT = 16384,
  parameter int INIT_LONG  = 32768,
  parameter int AFC_SHORT  = 16,
  parameter int AFC_LONG   = 64,
  parameter int CNT_W      = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             sym_stb,
  input  logic             tlock,
  input  logic             pull_ok,
  input  logic             pull_fail,
  input  logic             car_ok,
  input  logic             init_len_sel,
  input  logic             afc_sel,
  input  logic             afc_len_sel,
  input  logic [CNT_W-1:0] cnt,
  output cacq_st_e         state,
  output logic             cnt_clr,
  output logic             scan_step,
  output logic             scan_clr
);

  localparam logic [CNT_W-1:0] INIT_S_LAST = CNT_W'(INIT_SHORT - 1);
  localparam logic [CNT_W-1:0] INIT_L_LAST = CNT_W'(INIT_LONG - 1);
  localparam logic [CNT_W-1:0] AFC_S_LAST  = CNT_W'(AFC_SHORT - 1);
  localparam logic [CNT_W-1:0] AFC_L_LAST  = CNT_W'(AFC_LONG - 1);

  cacq_st_e         st_q, st_nx;
  cacq_st_e         retry_st;
  logic [CNT_W-1:0] init_last, afc_last;
  logic             in_pull;

  assign init_last = init_len_sel ? INIT_L_LAST : INIT_S_LAST;
  assign afc_last  = afc_len_sel  ? AFC_L_LAST  : AFC_S_LAST;
  assign retry_st  = afc_sel ? ST_AFC : ST_SCAN;
  assign in_pull   = (st_q == ST_COARSE) || (st_q == ST_DDPULL);

  always_comb begin
    st_nx = st_q;
    if (restart) begin
      st_nx = ST_IDLE;
    end else if (sym_stb) begin
      if (!tlock) begin
        st_nx = ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE:   st_nx = ST_INIT;
          ST_INIT:   if (cnt == init_last) st_nx = retry_st;
          ST_AFC:    if (cnt == afc_last)  st_nx = ST_COARSE;
          ST_SCAN:   st_nx = ST_COARSE;
          ST_COARSE: begin
            if (pull_fail)    st_nx = retry_st;
            else if (pull_ok) st_nx = ST_DDPULL;
          end
          ST_DDPULL: begin
            if (pull_fail)    st_nx = retry_st;
            else if (pull_ok) st_nx = ST_LOCK;
          end
          ST_LOCK:   if (!car_ok) st_nx = ST_DDPULL;
          default:   st_nx = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nx;
  end

  assign state     = st_q;
  assign cnt_clr   = (st_nx != st_q);
  assign scan_step = !restart && sym_stb && tlock && in_pull && pull_fail && !afc_sel;
  assign scan_clr  = (st_nx == ST_IDLE);

  // R2
  hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_stb && !restart) |=> $stable(st_q));

  // R11
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (st_q == ST_IDLE));

  // R10
  tlock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && !tlock && !restart) |=> (st_q == ST_IDLE));

  // R6
  scan_one_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN && sym_stb && tlock && !restart) |=> (st_q == ST_COARSE));

  // R14
  no_unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 3'b101);

endmodule

// File: rtl/carrier_acq_ctrl.sv
module carrier_acq_ctrl
  import cacq_pkg::*;
#(
  parameter int INIT_SHORT = 16384,
  parameter int INIT_LONG  = 32768,
  parameter int AFC_SHORT  = 16,
  parameter int AFC_LONG   = 64,
  parameter int SCAN_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              sym_stb,
  input  logic              tlock,
  input  logic              pull_ok,
  input  logic              pull_fail,
  input  logic              car_ok,
  input  logic              init_len_sel,
  input  logic              afc_sel,
  input  logic              afc_len_sel,
  input  logic              pib_sel,
  input  logic              trk_sel,
  input  logic [1:0]        cma_mu_sel,
  input  logic [1:0]        dd_mu_sel,
  output logic [2:0]        status,
  output logic [1:0]        eq_mode,
  output logic              pe_en,
  output logic              cl_lock,
  output logic              bw_code,
  output logic              bw_trk,
  output logic [3:0]        mu_shift,
  output logic [SCAN_W-1:0] scan_ofs
);

  localparam int CNT_MAX = (INIT_LONG > AFC_LONG) ? INIT_LONG : AFC_LONG;
  localparam int CNT_W   = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;

  cacq_st_e         state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, scan_step, scan_clr;

  cacq_fsm #(
    .INIT_SHORT (INIT_SHORT),
    .INIT_LONG  (INIT_LONG),
    .AFC_SHORT  (AFC_SHORT),
    .AFC_LONG   (AFC_LONG),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .sym_stb      (sym_stb),
    .tlock        (tlock),
    .pull_ok      (pull_ok),
    .pull_fail    (pull_fail),
    .car_ok       (car_ok),
    .init_len_sel (init_len_sel),
    .afc_sel      (afc_sel),
    .afc_len_sel  (afc_len_sel),
    .cnt          (cnt),
    .state        (state),
    .cnt_clr      (cnt_clr),
    .scan_step    (scan_step),
    .scan_clr     (scan_clr)
  );

  cacq_sym_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (sym_stb),
    .cnt   (cnt)
  );

  cacq_scan_cnt #(.SCAN_W(SCAN_W)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (scan_clr),
    .step  (scan_step),
    .ofs   (scan_ofs)
  );

  always_comb begin
    status   = state;
    eq_mode  = EQ_CMA;
    pe_en    = 1'b1;
    cl_lock  = 1'b0;
    bw_code  = 1'b0;
    bw_trk   = 1'b0;
    mu_shift = CMA_SHIFT_BASE - {2'b00, cma_mu_sel};
    unique case (state)
      ST_IDLE: begin
        eq_mode  = EQ_INIT;
        pe_en    = 1'b0;
        mu_shift = 4'd0;
      end
      ST_INIT: pe_en = 1'b0;
      ST_COARSE, ST_DDPULL: bw_code = pib_sel;
      ST_LOCK: begin
        eq_mode  = EQ_DD;
        cl_lock  = 1'b1;
        bw_code  = trk_sel;
        bw_trk   = 1'b1;
        mu_shift = DD_SHIFT_BASE - {2'b00, dd_mu_sel};
      end
      default: ;
    endcase
  end

  // R8
  scan_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'b100 && sym_stb && tlock && !restart && pull_fail && !afc_sel)
      |=> (scan_ofs == $past(scan_ofs) + 1'b1) && (status == 3'b011));

  // R7
  lock_dd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cl_lock |-> (eq_mode == 2'b10) && pe_en);

endmodule

// File: tb/carrier_acq_ctrl_tb.sv
module carrier_acq_ctrl_tb;

  localparam int INIT_S = 20;
  localparam int INIT_L = 40;
  localparam int AFC_S  = 16;
  localparam int AFC_L  = 64;
  localparam int SW     = 4;

  logic          clk = 1'b0;
  logic          rst_n, restart, sym_stb, tlock, pull_ok, pull_fail, car_ok;
  logic          init_len_sel, afc_sel, afc_len_sel, pib_sel, trk_sel;
  logic [1:0]    cma_mu_sel, dd_mu_sel;
  logic [2:0]    status;
  logic [1:0]    eq_mode;
  logic          pe_en, cl_lock, bw_code, bw_trk;
  logic [3:0]    mu_shift;
  logic [SW-1:0] scan_ofs;

  int checks = 0;
  int errors = 0;
  int bad_code = 0;

  always #10 clk = ~clk;

  carrier_acq_ctrl #(
    .INIT_SHORT (INIT_S), .INIT_LONG (INIT_L),
    .AFC_SHORT  (AFC_S),  .AFC_LONG  (AFC_L),
    .SCAN_W     (SW)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .restart (restart), .sym_stb (sym_stb),
    .tlock (tlock), .pull_ok (pull_ok), .pull_fail (pull_fail), .car_ok (car_ok),
    .init_len_sel (init_len_sel), .afc_sel (afc_sel), .afc_len_sel (afc_len_sel),
    .pib_sel (pib_sel), .trk_sel (trk_sel), .cma_mu_sel (cma_mu_sel),
    .dd_mu_sel (dd_mu_sel), .status (status), .eq_mode (eq_mode), .pe_en (pe_en),
    .cl_lock (cl_lock), .bw_code (bw_code), .bw_trk (bw_trk), .mu_shift (mu_shift),
    .scan_ofs (scan_ofs)
  );

  always @(negedge clk) if (rst_n && status == 3'b101) bad_code++;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic sym(input logic ok, input logic fail);
    @(negedge clk);
    pull_ok = ok; pull_fail = fail; sym_stb = 1'b1;
    @(negedge clk);
    pull_ok = 1'b0; pull_fail = 1'b0; sym_stb = 1'b0;
  endtask

  task automatic syms(input int n);
    for (int i = 0; i < n; i++) sym(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; restart = 1'b0; sym_stb = 1'b0; tlock = 1'b0;
    pull_ok = 1'b0; pull_fail = 1'b0; car_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "status", status, 0);
    chk("R1", "eq_mode", eq_mode, 0);
    chk("R1", "pe_en", pe_en, 0);
    chk("R1", "cl_lock", cl_lock, 0);
    chk("R1", "bw", {bw_code, bw_trk}, 0);
    chk("R12", "mu idle", mu_shift, 0);
    chk("R1", "scan", scan_ofs, 0);
  endtask

  task automatic t_scan_path();
    init_len_sel = 0; afc_sel = 0; pib_sel = 1; trk_sel = 0;
    cma_mu_sel = 2'd2; dd_mu_sel = 2'd1;
    tlock = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "no strobe idle", status, 0);
    sym(1'b0, 1'b0);
    chk("R2", "to initial", status, 1);
    chk("R3", "eq cma", eq_mode, 1);
    chk("R3", "pe off", pe_en, 0);
    syms(INIT_S - 1);
    chk("R3", "initial still", status, 1);
    sym(1'b0, 1'b0);
    chk("R4", "to scan", status, 3);
    chk("R6", "scan first ofs", scan_ofs, 0);
    sym(1'b0, 1'b0);
    chk("R6", "to coarse", status, 4);
    chk("R13", "bw pull", {bw_code, bw_trk}, 2);
    chk("R12", "mu cma", mu_shift, 8);
    chk("R12", "pe on", pe_en, 1);
    @(negedge clk); pull_ok = 1'b1; @(negedge clk); pull_ok = 1'b0;
    chk("R2", "ok without strobe", status, 4);
    sym(1'b0, 1'b1);
    chk("R8", "fail to scan", status, 3);
    chk("R8", "ofs step", scan_ofs, 1);
    sym(1'b0, 1'b0);
    sym(1'b1, 1'b1);
    chk("R8", "fail wins state", status, 3);
    chk("R8", "fail wins ofs", scan_ofs, 2);
    sym(1'b0, 1'b0);
    sym(1'b1, 1'b0);
    chk("R7", "to dd pull", status, 6);
    chk("R13", "bw dd pull", {bw_code, bw_trk}, 2);
    sym(1'b1, 1'b0);
    chk("R7", "to lock", status, 7);
    chk("R7", "eq dd", eq_mode, 2);
    chk("R7", "lock flag", cl_lock, 1);
    chk("R12", "mu dd", mu_shift, 12);
    chk("R13", "bw track", {bw_code, bw_trk}, 1);
    car_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "car_ok without strobe", status, 7);
    sym(1'b0, 1'b0);
    chk("R9", "lock loss", status, 6);
    car_ok = 1'b1;
    sym(1'b1, 1'b0);
    tlock = 1'b0;
    sym(1'b0, 1'b0);
    chk("R10", "tlock loss", status, 0);
    chk("R10", "ofs cleared", scan_ofs, 0);
  endtask

  task automatic t_afc_path();
    do_reset();
    init_len_sel = 1; afc_sel = 1; afc_len_sel = 1;
    tlock = 1'b1;
    sym(1'b0, 1'b0);
    syms(INIT_L - 1);
    chk("R3", "long initial", status, 1);
    sym(1'b0, 1'b0);
    chk("R4", "to afc", status, 2);
    syms(AFC_L - 1);
    chk("R5", "afc long still", status, 2);
    sym(1'b0, 1'b0);
    chk("R5", "afc long done", status, 4);
    sym(1'b1, 1'b0);
    sym(1'b0, 1'b1);
    chk("R8", "dd fail to afc", status, 2);
    chk("R8", "ofs unchanged", scan_ofs, 0);
    afc_len_sel = 0;
    syms(AFC_S - 1);
    chk("R5", "afc short still", status, 2);
    sym(1'b0, 1'b0);
    chk("R5", "afc short done", status, 4);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    chk("R11", "restart idle", status, 0);
    sym(1'b0, 1'b0);
    chk("R11", "reacquire", status, 1);
    @(negedge clk); restart = 1'b1; sym_stb = 1'b1; pull_ok = 1'b1;
    @(negedge clk); restart = 1'b0; sym_stb = 1'b0; pull_ok = 1'b0;
    chk("R11", "restart priority", status, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    init_len_sel = 0; afc_sel = 0; afc_len_sel = 0; pib_sel = 0; trk_sel = 0;
    cma_mu_sel = 2'd0; dd_mu_sel = 2'd0;
    t_reset();
    t_scan_path();
    t_afc_path();
    chk("R14", "code 101 cycles", bad_code, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule